// File: doc/BRIEF.md
# External Interrupt Pin Detector

The block turns six asynchronous external interrupt pins into request lines for the interrupt priority logic. Each pin first passes through a two-flop synchroniser and then an optional digital noise filter. The filter only accepts a new level after three consecutive samples agree, and its sample rate is the system clock divided by a per-channel factor. A per-channel detector then raises a request on a low level, a falling edge, a rising edge, or either edge.

Edge requests are sticky. They stay set until the CPU acknowledges them or software clears them. A level request follows the filtered pin and cannot be cleared while the pin is still low. Software sets the configuration one channel at a time through a simple write port. A combinational wake output lets a stopped-clock standby controller leave standby: it is high when a level-mode pin is held low, or when any request is already pending.

Top module: `ext_irq_detect`

## Requirements
- R1: A configuration write applies to the channel given by `cfg_ch_i` (0 to 5) only. Writes with an index of 6 or 7 change no channel.
- R2: Mode encoding is 0 = low level, 1 = falling edge, 2 = rising edge, 3 = both edges. After reset every channel is in falling-edge mode with the filter off and divider code 0. All requests are low and `wake_o` is low while the pins are high.
- R3: In an edge mode, a filtered transition that matches the mode sets that channel's request bit. A transition that does not match leaves it low. The bit stays set without further pin activity.
- R4: In low-level mode, `req_o[k]` is high while the filtered pin is low and low once it is high. Pulses on `ack_i[k]` or `clr_i[k]` leave it high while the pin stays low.
- R5: In an edge mode, a one-cycle pulse on `ack_i[k]` or on `clr_i[k]` clears the pending request.
- R6: With the filter off, a one-cycle pin pulse is detected. With the filter on, a pulse lasting two sample periods or less is rejected.
- R7: Filter divider code 0/1/2/3 selects a sample period of 1/8/32/64 clocks (period P). With the filter on, the request does not appear within 2P cycles of a pin change and does appear within 3P+8 cycles.
- R8: A configuration write to a channel clears its pending edge request. Edges in the two cycles after the write are ignored.
- R9: `wake_o` is high whenever any request is high. It is also high, with no clock edge needed, whenever a channel in low-level mode sees its raw pin low.
- R10: With the filter off, an edge-mode request rises on the fourth rising clock edge after the pin changes, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pin_i | input | 6 | Raw external interrupt pins, asynchronous |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_ch_i | input | 3 | Channel index of the write |
| cfg_mode_i | input | 2 | Detection mode to write |
| cfg_flt_i | input | 1 | Filter enable to write |
| cfg_div_i | input | 2 | Filter divider code to write |
| ack_i | input | 6 | Per-channel CPU acknowledge |
| clr_i | input | 6 | Per-channel software clear |
| req_o | output | 6 | Per-channel request to priority logic |
| wake_o | output | 1 | Standby wake request |

## Verification
A corrupted pending flag shows up on `req_o` as a request that either persists after acknowledge or vanishes without one. The sweep across every channel and mode catches it within one stimulus step, about eight clocks. A wrong filter count or divider shows up as a request arriving too early or too late against the 2P and 3P+8 windows. It can also show up as a rejected glitch getting through. A stale edge history after reconfiguration would raise a request right after the write. The bench samples that at once.

// File: rtl/eirq_pkg.sv
package eirq_pkg;
  typedef enum logic [1:0] {
    MODE_LOW  = 2'd0,
    MODE_FALL = 2'd1,
    MODE_RISE = 2'd2,
    MODE_BOTH = 2'd3
  } mode_e;

  localparam int CNT_W = 6;

  // terminal count of the sample prescaler
  function automatic logic [CNT_W-1:0] div_limit(input logic [1:0] sel);
    case (sel)
      2'd0:    div_limit = CNT_W'(0);
      2'd1:    div_limit = CNT_W'(7);
      2'd2:    div_limit = CNT_W'(31);
      default: div_limit = CNT_W'(63);
    endcase
  endfunction
endpackage

// File: rtl/eirq_sync.sv
module eirq_sync #(
  parameter int W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '1;
      s2_q <= '1;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end

  assign q_o = s2_q;
endmodule

// File: rtl/eirq_filter.sv
module eirq_filter
  import eirq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       d_i,
  input  logic       en_i,
  input  logic [1:0] div_i,
  output logic       q_o
);
  logic [CNT_W-1:0] cnt_q, lim;
  logic [1:0]       smp_q;
  logic             tick, q_q;

  assign lim  = div_limit(div_i);
  assign tick = (cnt_q >= lim);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      smp_q <= 2'b11;
      q_q   <= 1'b1;
    end else begin
      cnt_q <= tick ? '0 : cnt_q + CNT_W'(1);
      if (tick) smp_q <= {smp_q[0], d_i};
      if (!en_i) q_q <= d_i;
      else if (tick && (smp_q == {2{d_i}})) q_q <= d_i;
    end
  end

  assign q_o = q_q;
endmodule

// File: rtl/eirq_detect.sv
module eirq_detect
  import eirq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lvl_i,
  input  logic [1:0] mode_i,
  input  logic       cfg_wr_i,
  input  logic       clr_i,
  output logic       req_o
);
  logic       prev_q, flag_q, hit;
  logic [1:0] hold_q;

  always_comb begin
    case (mode_e'(mode_i))
      MODE_FALL: hit = prev_q & ~lvl_i;
      MODE_RISE: hit = ~prev_q & lvl_i;
      MODE_BOTH: hit = prev_q ^ lvl_i;
      default:   hit = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      flag_q <= 1'b0;
      hold_q <= '0;
    end else begin
      prev_q <= lvl_i;
      hold_q <= cfg_wr_i ? 2'b11 : {1'b0, hold_q[1]};
      if (cfg_wr_i)                   flag_q <= 1'b0;
      else if (hit && hold_q == 2'b0) flag_q <= 1'b1;  // new edge wins over clear
      else if (clr_i)                 flag_q <= 1'b0;
    end
  end

  assign req_o = (mode_e'(mode_i) == MODE_LOW) ? ~lvl_i : flag_q;
endmodule

// File: rtl/ext_irq_detect.sv
module ext_irq_detect
  import eirq_pkg::*;
#(
  parameter  int NCH  = 6,
  localparam int CH_W = $clog2(NCH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NCH-1:0]  pin_i,
  input  logic            cfg_we_i,
  input  logic [CH_W-1:0] cfg_ch_i,
  input  logic [1:0]      cfg_mode_i,
  input  logic            cfg_flt_i,
  input  logic [1:0]      cfg_div_i,
  input  logic [NCH-1:0]  ack_i,
  input  logic [NCH-1:0]  clr_i,
  output logic [NCH-1:0]  req_o,
  output logic            wake_o
);
  logic [NCH-1:0] pin_s, cfg_wr, lvl_mask;

  eirq_sync #(.W(NCH)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pin_i),
    .q_o   (pin_s)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic [1:0] mode_q, div_q;
    logic       flt_q, filt;

    assign cfg_wr[k] = cfg_we_i && (int'(cfg_ch_i) == k);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        mode_q <= MODE_FALL;
        div_q  <= '0;
        flt_q  <= 1'b0;
      end else if (cfg_wr[k]) begin
        mode_q <= cfg_mode_i;
        div_q  <= cfg_div_i;
        flt_q  <= cfg_flt_i;
      end
    end

    assign lvl_mask[k] = (mode_e'(mode_q) == MODE_LOW);

    eirq_filter u_flt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .d_i   (pin_s[k]),
      .en_i  (flt_q),
      .div_i (div_q),
      .q_o   (filt)
    );

    eirq_detect u_det (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .lvl_i   (filt),
      .mode_i  (mode_q),
      .cfg_wr_i(cfg_wr[k]),
      .clr_i   (ack_i[k] | clr_i[k]),
      .req_o   (req_o[k])
    );
  end

  // combinational so it works with the clock stopped
  assign wake_o = (|req_o) | (|(lvl_mask & ~pin_i));
endmodule

// File: rtl/ext_irq_detect_chk.sv
module ext_irq_detect_chk #(
  parameter int NCH = 6
) (
  input logic           clk_i,
  input logic           rst_ni,
  input logic [NCH-1:0] pin_i,
  input logic [NCH-1:0] ack_i,
  input logic [NCH-1:0] clr_i,
  input logic [NCH-1:0] cfg_wr,
  input logic [NCH-1:0] lvl_mask,
  input logic [NCH-1:0] req_o,
  input logic           wake_o
);
  p_wake_on_req_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|req_o) |-> wake_o);

  p_wake_on_level_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(lvl_mask & ~pin_i)) |-> wake_o);

  p_req_known_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$isunknown(req_o));

  for (genvar k = 0; k < NCH; k++) begin : g_chk
    p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!lvl_mask[k] && req_o[k] && !ack_i[k] && !clr_i[k] && !cfg_wr[k])
        |=> req_o[k]);

    p_cfg_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cfg_wr[k] |=> (lvl_mask[k] || !req_o[k]));
  end
endmodule

bind ext_irq_detect ext_irq_detect_chk #(.NCH(NCH)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pin_i   (pin_i),
  .ack_i   (ack_i),
  .clr_i   (clr_i),
  .cfg_wr  (cfg_wr),
  .lvl_mask(lvl_mask),
  .req_o   (req_o),
  .wake_o  (wake_o)
);

// File: tb/ext_irq_detect_tb.sv
`timescale 1ns/1ps
module ext_irq_detect_tb;
  localparam int NCH = 6;

  logic           clk = 0;
  logic           rst_n = 0;
  logic [NCH-1:0] pin = '1;
  logic           cfg_we = 0;
  logic [2:0]     cfg_ch = '0;
  logic [1:0]     cfg_mode = '0;
  logic           cfg_flt = 0;
  logic [1:0]     cfg_div = '0;
  logic [NCH-1:0] ack = '0, clr = '0;
  logic [NCH-1:0] req;
  logic           wake;
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  ext_irq_detect u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin), .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch),
    .cfg_mode_i(cfg_mode), .cfg_flt_i(cfg_flt), .cfg_div_i(cfg_div),
    .ack_i(ack), .clr_i(clr), .req_o(req), .wake_o(wake)
  );

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", r, act, exp);
    end
  endtask

  task automatic cfg(int ch, int m, bit f, int d);
    cfg_we = 1; cfg_ch = 3'(ch); cfg_mode = 2'(m); cfg_flt = f; cfg_div = 2'(d);
    cyc(1);
    cfg_we = 0;
  endtask

  task automatic pulse(logic [NCH-1:0] a, logic [NCH-1:0] c);
    ack = a; clr = c;
    cyc(1);
    ack = '0; clr = '0;
  endtask

  initial begin
    cyc(3);
    rst_n = 1;
    cyc(2);
    chk("R2 reset req", 32'(req), 0);
    chk("R2 reset wake", 32'(wake), 0);

    // sweep channels x modes, filter off
    for (int ch = 0; ch < NCH; ch++) begin
      for (int m = 0; m < 4; m++) begin
        logic [NCH-1:0] bitv, e_f, e_r;
        bitv = NCH'(1) << ch;
        e_f  = (m != 2) ? bitv : '0;
        e_r  = (m >= 2) ? bitv : '0;
        cfg(ch, m, 0, 0);
        cyc(3);
        pulse('0, '1);
        pin[ch] = 0;
        cyc(8);
        chk((m == 0) ? "R4 level low" : "R3 fall", 32'(req), 32'(e_f));
        chk("R9 wake follows req", 32'(wake), 32'(e_f != 0));
        if (m == 0) begin
          pulse(bitv, bitv);
          cyc(2);
          chk("R4 clear while low", 32'(req), 32'(bitv));
        end else if (ch % 2 == 0) begin
          pulse(bitv, '0);
          cyc(1);
          chk("R5 ack clears", 32'(req), 0);
        end else begin
          pulse('0, bitv);
          cyc(1);
          chk("R5 clr clears", 32'(req), 0);
        end
        pin[ch] = 1;
        cyc(8);
        chk((m == 0) ? "R4 level high" : "R3 rise", 32'(req), 32'(e_r));
        pulse('0, '1);
      end
    end

    // R10 exact latency, channel 2 in both-edge mode
    cyc(2);
    pin[2] = 0;
    cyc(3);
    chk("R10 not before edge 4", 32'(req), 0);
    cyc(1);
    chk("R10 at edge 4", 32'(req), 32'h4);
    pin[2] = 1;
    cyc(8);
    pulse('0, '1);

    // R9 wake without clock edge
    cfg(4, 0, 0, 0);
    cyc(3);
    pin[4] = 0;
    #1;
    chk("R9 wake comb", 32'(wake), 1);
    chk("R9 req not yet", 32'(req), 0);
    pin[4] = 1;
    cyc(8);
    chk("R9 wake released", 32'(wake), 0);
    cfg(4, 1, 0, 0);

    // R8 config write clears pending flag
    cfg(1, 1, 0, 0);
    cyc(3);
    pin[1] = 0;
    cyc(8);
    chk("R8 flag set", 32'(req), 32'h2);
    cfg(1, 3, 0, 0);
    cyc(2);
    chk("R8 cleared by write", 32'(req), 0);
    pin[1] = 1;
    cyc(8);
    chk("R8 new edge after write", 32'(req), 32'h2);
    pulse('0, '1);

    // R1 out-of-range channel write ignored
    for (int ch = 0; ch < NCH; ch++) cfg(ch, 1, 0, 0);
    cfg(7, 2, 0, 0);
    cfg(6, 0, 0, 0);
    cyc(3);
    chk("R1 no level via bad index", 32'(req), 0);
    pin = '0;
    cyc(8);
    chk("R1 all fall", 32'(req), 32'h3f);
    pulse('0, '1);
    pin = '1;
    cyc(8);
    chk("R1 rise ignored", 32'(req), 0);

    // R6 filter off passes one-cycle glitch
    cfg(3, 3, 0, 0);
    cyc(3);
    pin[3] = 0;
    cyc(1);
    pin[3] = 1;
    cyc(8);
    chk("R6 glitch passes unfiltered", 32'(req), 32'h8);
    pulse('0, '1);

    // R6/R7 filter on, each divider
    for (int d = 0; d < 4; d++) begin
      int p;
      p = (d == 0) ? 1 : (d == 1) ? 8 : (d == 2) ? 32 : 64;
      cfg(3, 3, 1, d);
      cyc(3 * p + 8);
      pulse('0, '1);
      pin[3] = 0;
      cyc(2 * p);
      pin[3] = 1;
      cyc(3 * p + 8);
      chk("R6 short pulse rejected", 32'(req), 0);
      pin[3] = 0;
      cyc(2 * p);
      chk("R7 not within 2P", 32'(req), 0);
      cyc(p + 8);
      chk("R7 within 3P+8", 32'(req), 32'h8);
      pin[3] = 1;
      cyc(3 * p + 8);
      pulse('0, '1);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule